// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one event channel of a timer that shares a free-running main counter with its neighbours. Software programs a channel configuration word and a comparator value written as two 32-bit halves. The channel watches the main counter and emits a single-cycle match event when the counter catches up with the comparator. The interrupt logic consumes that event.

Two modes set what happens after a match. In one-shot mode the channel fires once and then goes idle. In periodic mode the comparator advances by a hidden period register and the channel fires again on each later match. A channel can also be forced to compare only the low 32 bits. In that narrow mode a one-shot channel raises an extra event when the low half of the counter reaches all ones, if that point comes before the match. In periodic mode a comparator write normally changes only the hidden period. A self-clearing set-value bit lets the same write load the comparator itself.

Top module: `cmp_timer_channel`

## Requirements
- R1: After reset the comparator reads all ones, the period is zero, the channel is not armed and no event is produced.
- R2: An armed one-shot channel produces exactly one event, for the counter value at which the signed difference comparator minus counter first becomes zero or negative. It then disarms.
- R3: An armed periodic channel with a nonzero period adds the period to the comparator on every match. If the comparator is still behind after an addition, it keeps advancing one step per cycle with no further event until it is ahead of the counter again.
- R4: In periodic mode a comparator half write loads the comparator half only when the set-value bit is 1. It always loads the same half of the period, with the period's top bit cleared (bit 31 in 32-bit mode, bit 63 otherwise).
- R5: The set-value bit returns to 0 after any write to either comparator half.
- R6: Writing the configuration with the 32-bit bit set clears the upper 32 bits of the comparator and of the period. In 32-bit mode, match tests use only the low 32 bits, periodic additions wrap modulo 2^32, and high-half writes are ignored.
- R7: When a 32-bit one-shot channel is armed and the low counter half would reach 0xFFFFFFFF before the match, an event fires when it reaches 0xFFFFFFFF. The real match event fires later.
- R8: A rising main enable arms the channel if its enable bit is 1 and its comparator is not all ones. A low main enable disarms the channel.
- R9: Clearing the channel enable bit disarms the channel and suppresses its event. Setting it while the main enable is high arms the channel, and so does a comparator write while both enables are high.
- R10: Configuration bits are: bit 0 channel enable, bit 1 periodic, bit 2 32-bit mode, bit 3 set-value. A low-half write replaces comparator bits 31:0 and a high-half write replaces bits 63:32, each leaving the other half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_cnt_i | input | 64 | Shared main counter value |
| main_en_i | input | 1 | Global enable of the timer block |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Configuration write data (bit map in R10) |
| cmp_lo_we_i | input | 1 | Write strobe for comparator bits 31:0 |
| cmp_hi_we_i | input | 1 | Write strobe for comparator bits 63:32 |
| cmp_wdata_i | input | 32 | Comparator half write data |
| match_evt_o | output | 1 | One-cycle match or wrap event |
| armed_o | output | 1 | Channel is waiting for an event |
| cmp_o | output | 64 | Current comparator value |

## Verification
The checker assumes that the main counter changes by at most one per clock and that at most one of the three write strobes is high in any cycle. Under those rules the wrap point and every match are visible in some cycle. The stimulus advances the counter by single steps or holds it still, and it changes it by a jump only while the channel is disarmed or while catch-up is under test. It issues one write per cycle. Random trials pick a 64-bit base and a short forward distance, so every expected match falls inside the window that is observed.

// File: rtl/cmp_timer_pkg.sv
// Shared types for the comparator timer channel.
// Assumes: configuration word is four bits wide, layout fixed by tmr_cfg_t.
package cmp_timer_pkg;
    localparam int CFG_W = 4;

    // Channel configuration, bit 0 is the enable.
    typedef struct packed {
        logic setval;    // bit 3: next comparator write also loads the comparator
        logic narrow;    // bit 2: 32-bit comparison
        logic periodic;  // bit 1: periodic reload
        logic enable;    // bit 0: channel enable
    } tmr_cfg_t;
endpackage

// File: rtl/cmp_timer_regs.sv
// Comparator and hidden period storage for one channel.
// Applies half writes, narrow-mode truncation and periodic reload.
// Assumes: at most one of trunc/lo/hi write per cycle; reload only when idle.
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  tmr_cfg_t              cfg_q_i,
    input  logic                  trunc_i,
    input  logic                  lo_we_i,
    input  logic                  hi_we_i,
    input  logic [CNT_W/2-1:0]    wdata_i,
    input  logic                  reload_i,
    output logic [CNT_W-1:0]      cmp_q_o,
    output logic [CNT_W-1:0]      cmp_d_o,
    output logic [CNT_W-1:0]      reload_sum_o,
    output logic                  period_zero_o
);
    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0]  cmp_q, per_q, per_d;
    logic [HALF_W-1:0] wr_clip;
    logic              load_cmp;

    // Sum used for periodic reload, wrapping at the active width.
    always_comb begin
        if (cfg_q_i.narrow)
            reload_sum_o = {{HALF_W{1'b0}}, cmp_q[HALF_W-1:0] + per_q[HALF_W-1:0]};
        else
            reload_sum_o = cmp_q + per_q;
    end

    // Next comparator and period from writes, truncation and reload.
    always_comb begin
        cmp_d_o  = cmp_q;
        per_d    = per_q;
        load_cmp = !cfg_q_i.periodic || cfg_q_i.setval;
        wr_clip  = {1'b0, wdata_i[HALF_W-2:0]};
        if (trunc_i) begin
            cmp_d_o = {{HALF_W{1'b0}}, cmp_q[HALF_W-1:0]};
            per_d   = {{HALF_W{1'b0}}, per_q[HALF_W-1:0]};
        end else if (lo_we_i) begin
            if (load_cmp)
                cmp_d_o[HALF_W-1:0] = wdata_i;
            if (cfg_q_i.periodic)
                per_d[HALF_W-1:0] = cfg_q_i.narrow ? wr_clip : wdata_i;
        end else if (hi_we_i && !cfg_q_i.narrow) begin
            if (load_cmp)
                cmp_d_o[CNT_W-1:HALF_W] = wdata_i;
            if (cfg_q_i.periodic)
                per_d[CNT_W-1:HALF_W] = wr_clip;
        end else if (reload_i) begin
            cmp_d_o = reload_sum_o;
        end
    end

    // Register update; comparator resets to all ones, period to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
            per_q <= '0;
        end else begin
            cmp_q <= cmp_d_o;
            per_q <= per_d;
        end
    end

    assign cmp_q_o       = cmp_q;
    assign period_zero_o = (per_q == '0);
endmodule

// File: rtl/cmp_timer_match.sv
// Combinational match tests: due, still-behind after reload, wrap need.
// Assumes: signed difference of the active width decides "reached".
module cmp_timer_match #(
    parameter int CNT_W = 64
) (
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [CNT_W-1:0]   cmp_i,
    input  logic [CNT_W-1:0]   reload_sum_i,
    input  logic [CNT_W/2-1:0] cmp_next_lo_i,
    input  logic               narrow_i,
    input  logic               narrow_next_i,
    input  logic               periodic_next_i,
    output logic               due_o,
    output logic               behind_o,
    output logic               wrap_need_o,
    output logic               at_wrap_o
);
    localparam int HALF_W = CNT_W / 2;

    logic [HALF_W-1:0] ahead_lo, dist_lo, room_lo;

    // True when target minus counter is zero or negative at the active width.
    function automatic logic reached(input logic [CNT_W-1:0] tgt,
                                     input logic [CNT_W-1:0] cnt,
                                     input logic             nar);
        logic [CNT_W-1:0]  full;
        logic [HALF_W-1:0] half;
        full = tgt - cnt;
        half = tgt[HALF_W-1:0] - cnt[HALF_W-1:0];
        if (nar)
            return half[HALF_W-1] || (half == '0);
        return full[CNT_W-1] || (full == '0);
    endfunction

    // Current and post-reload match state.
    always_comb begin
        due_o    = reached(cmp_i, cnt_i, narrow_i);
        behind_o = reached(reload_sum_i, cnt_i, narrow_i);
    end

    // Distance to match versus distance to the low-half wrap point.
    always_comb begin
        ahead_lo    = cmp_next_lo_i - cnt_i[HALF_W-1:0];
        dist_lo     = (ahead_lo[HALF_W-1] || ahead_lo == '0) ? HALF_W'(1) : ahead_lo;
        room_lo     = '1 - cnt_i[HALF_W-1:0];
        wrap_need_o = narrow_next_i && !periodic_next_i && (room_lo < dist_lo);
        at_wrap_o   = &cnt_i[HALF_W-1:0];
    end
endmodule

// File: rtl/cmp_timer_arm.sv
// Arming state, wrap flag, catch-up flag and the registered event.
// Assumes: disarm beats arm, arm beats hold, hold beats evaluation.
module cmp_timer_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req_i,
    input  logic disarm_req_i,
    input  logic hold_i,
    input  logic due_i,
    input  logic behind_i,
    input  logic at_wrap_i,
    input  logic wrap_need_i,
    input  logic periodic_i,
    input  logic period_zero_i,
    output logic armed_o,
    output logic evt_o,
    output logic reload_o
);
    logic armed_q, wrap_q, catch_q, evt_q;
    logic armed_d, wrap_d, catch_d, evt_d;

    // Next state of the arming logic.
    always_comb begin
        armed_d  = armed_q;
        wrap_d   = wrap_q;
        catch_d  = catch_q;
        evt_d    = 1'b0;
        reload_o = 1'b0;
        if (disarm_req_i) begin
            armed_d = 1'b0;
            wrap_d  = 1'b0;
            catch_d = 1'b0;
        end else if (arm_req_i) begin
            armed_d = 1'b1;
            wrap_d  = wrap_need_i;
            catch_d = 1'b0;
        end else if (!hold_i && armed_q) begin
            if (wrap_q) begin
                if (at_wrap_i) begin
                    evt_d  = 1'b1;
                    wrap_d = 1'b0;
                end
            end else if (due_i) begin
                if (periodic_i && !period_zero_i) begin
                    reload_o = 1'b1;
                    evt_d    = !catch_q;
                    catch_d  = behind_i;
                end else begin
                    evt_d   = 1'b1;
                    armed_d = 1'b0;
                end
            end else begin
                catch_d = 1'b0;
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            wrap_q  <= 1'b0;
            catch_q <= 1'b0;
            evt_q   <= 1'b0;
        end else begin
            armed_q <= armed_d;
            wrap_q  <= wrap_d;
            catch_q <= catch_d;
            evt_q   <= evt_d;
        end
    end

    assign armed_o = armed_q;
    assign evt_o   = evt_q;
endmodule

// File: rtl/cmp_timer_channel.sv
// Top of one comparator timer channel: configuration register, enable
// edge detection and the glue between storage, match and arming logic.
// Assumes: one write strobe per cycle; counter moves by at most one per clock.
module cmp_timer_channel
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] main_cnt_i,
    input  logic             main_en_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             cmp_lo_we_i,
    input  logic             cmp_hi_we_i,
    input  logic [CNT_W/2-1:0] cmp_wdata_i,
    output logic             match_evt_o,
    output logic             armed_o,
    output logic [CNT_W-1:0] cmp_o
);
    localparam int HALF_W = CNT_W / 2;

    tmr_cfg_t         cfg_q, cfg_d, cfg_wr;
    logic             main_en_q;
    logic             cmp_wr, arm_req, disarm_req, reload;
    logic             due, behind, wrap_need, at_wrap, period_zero;
    logic [CNT_W-1:0] cmp_q, cmp_d, reload_sum;

    assign cfg_wr = tmr_cfg_t'(cfg_wdata_i);
    assign cmp_wr = cmp_lo_we_i || cmp_hi_we_i;

    // Next configuration; set-value clears on any comparator write.
    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we_i)
            cfg_d = cfg_wr;
        else if (cmp_wr)
            cfg_d.setval = 1'b0;
    end

    // Configuration and main-enable history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            main_en_q <= 1'b0;
        end else begin
            cfg_q     <= cfg_d;
            main_en_q <= main_en_i;
        end
    end

    // Arm and disarm requests from enable edges and comparator writes.
    always_comb begin
        arm_req = (cfg_we_i && cfg_wr.enable && !cfg_q.enable && main_en_i)
               || (main_en_i && !main_en_q && cfg_d.enable && (cmp_q != '1))
               || (cmp_wr && main_en_i && cfg_q.enable);
        disarm_req = !main_en_i || !cfg_d.enable;
    end

    cmp_timer_regs #(.CNT_W(CNT_W)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_q_i      (cfg_q),
        .trunc_i      (cfg_we_i && cfg_wr.narrow),
        .lo_we_i      (cmp_lo_we_i),
        .hi_we_i      (cmp_hi_we_i),
        .wdata_i      (cmp_wdata_i),
        .reload_i     (reload),
        .cmp_q_o      (cmp_q),
        .cmp_d_o      (cmp_d),
        .reload_sum_o (reload_sum),
        .period_zero_o(period_zero)
    );

    cmp_timer_match #(.CNT_W(CNT_W)) match_i (
        .cnt_i          (main_cnt_i),
        .cmp_i          (cmp_q),
        .reload_sum_i   (reload_sum),
        .cmp_next_lo_i  (cmp_d[HALF_W-1:0]),
        .narrow_i       (cfg_q.narrow),
        .narrow_next_i  (cfg_d.narrow),
        .periodic_next_i(cfg_d.periodic),
        .due_o          (due),
        .behind_o       (behind),
        .wrap_need_o    (wrap_need),
        .at_wrap_o      (at_wrap)
    );

    cmp_timer_arm arm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_req_i    (arm_req),
        .disarm_req_i (disarm_req),
        .hold_i       (cfg_we_i || cmp_wr),
        .due_i        (due),
        .behind_i     (behind),
        .at_wrap_i    (at_wrap),
        .wrap_need_i  (wrap_need),
        .periodic_i   (cfg_q.periodic),
        .period_zero_i(period_zero),
        .armed_o      (armed_o),
        .evt_o        (match_evt_o),
        .reload_o     (reload)
    );

    assign cmp_o = cmp_q;
endmodule

// File: rtl/cmp_timer_channel_chk.sv
// Property checker for cmp_timer_channel, attached by bind below.
// Assumes: synchronous active-low reset; configuration layout per R10.
module cmp_timer_channel_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             main_en_i,
    input logic             cfg_we_i,
    input logic [3:0]       cfg_wdata_i,
    input logic             cmp_lo_we_i,
    input logic             cmp_hi_we_i,
    input logic             match_evt_o,
    input logic             armed_o,
    input logic [CNT_W-1:0] cmp_o,
    input logic [3:0]       cfg_q
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cmp_o == '1) && !armed_o && !match_evt_o);

    // R2
    evt_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt_o |-> $past(armed_o));

    // R5
    setval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_lo_we_i || cmp_hi_we_i) && !cfg_we_i |=> !cfg_q[3]);

    // R6
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[2] |-> (cmp_o[CNT_W-1:CNT_W/2] == '0));

    // R8
    main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !main_en_i |=> !armed_o);

    // R9
    chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i && !cfg_wdata_i[0] |=> !armed_o && !match_evt_o);
endmodule

bind cmp_timer_channel cmp_timer_channel_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .main_en_i  (main_en_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cmp_lo_we_i(cmp_lo_we_i),
    .cmp_hi_we_i(cmp_hi_we_i),
    .match_evt_o(match_evt_o),
    .armed_o    (armed_o),
    .cmp_o      (cmp_o),
    .cfg_q      (cfg_q)
);

// File: tb/cmp_timer_channel_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random one-shot trials.
module cmp_timer_channel_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] cnt;
    logic        main_en, cfg_we, lo_we, hi_we;
    logic [3:0]  cfg_wd;
    logic [31:0] wd;
    logic        evt, armed;
    logic [63:0] cmp;

    int          vectors = 0;
    int          errors  = 0;
    int          nf;
    logic [63:0] fires [8];
    bit          done = 0;

    always #2.5 clk = ~clk;

    cmp_timer_channel dut_i (
        .clk(clk), .rst_n(rst_n), .main_cnt_i(cnt), .main_en_i(main_en),
        .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cmp_lo_we_i(lo_we),
        .cmp_hi_we_i(hi_we), .cmp_wdata_i(wd), .match_evt_o(evt),
        .armed_o(armed), .cmp_o(cmp)
    );

    // Number of periodic hits first, first+per, ... not beyond last.
    function automatic int hits(input longint unsigned first, input longint unsigned per,
                                input longint unsigned last);
        return (last < first) ? 0 : int'((last - first) / per) + 1;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wcfg(input logic [3:0] v);
        cfg_wd = v; cfg_we = 1'b1; step(); cfg_we = 1'b0;
    endtask

    task automatic wlo(input logic [31:0] v);
        wd = v; lo_we = 1'b1; step(); lo_we = 1'b0;
    endtask

    task automatic whi(input logic [31:0] v);
        wd = v; hi_we = 1'b1; step(); hi_we = 1'b0;
    endtask

    task automatic set_main(input logic v);
        main_en = v; step();
    endtask

    // Run n cycles, optionally incrementing the counter, logging events.
    task automatic advance(input int n, input bit inc);
        nf = 0;
        for (int i = 0; i < n; i++) begin
            if (inc) cnt = cnt + 64'd1;
            step();
            if (evt) begin
                if (nf < 8) fires[nf] = cnt;
                nf++;
            end
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] base, tgt;
        void'($urandom(32'd2024));
        rst_n = 1'b0; cnt = '0; main_en = 1'b0; cfg_we = 1'b0; lo_we = 1'b0;
        hi_we = 1'b0; cfg_wd = '0; wd = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 cmp", cmp, '1);
        chk("R1 armed", 64'(armed), 64'd0);
        chk("R1 evt", 64'(evt), 64'd0);

        // R2 / R10 one-shot 64-bit with independent halves
        cnt = 64'd1000;
        wcfg(4'b0001);
        main_en = 1'b1;
        whi(32'h0);
        chk("R10 hi half", cmp, 64'h0000_0000_FFFF_FFFF);
        wlo(32'd1010);
        chk("R10 lo half", cmp, 64'd1010);
        advance(20, 1'b1);
        chk("R2 count", 64'(nf), 64'd1);
        chk("R2 value", fires[0], 64'd1010);
        chk("R2 disarm", 64'(armed), 64'd0);

        // R4 / R5 / R8 / R3 periodic setup and reload
        main_en = 1'b0;
        wcfg(4'b1011);
        wlo(32'd2010);
        chk("R4 setval loads cmp", cmp, 64'd2010);
        wlo(32'd10);
        chk("R5 setval cleared", cmp, 64'd2010);
        cnt = 64'd2000;
        set_main(1'b1);
        chk("R8 main rise arms", 64'(armed), 64'd1);
        advance(45, 1'b1);
        chk("R3 periodic count", 64'(nf), 64'(hits(2010, 10, 2045)));
        chk("R3 first", fires[0], 64'd2010);
        chk("R3 fourth", fires[3], 64'd2040);
        chk("R3 cmp after", cmp, 64'd2050);

        // R3 catch-up after a counter jump
        set_main(1'b0);
        cnt = 64'd2100;
        set_main(1'b1);
        advance(10, 1'b0);
        chk("R3 catchup single event", 64'(nf), 64'd1);
        chk("R3 catchup cmp", cmp, 64'd2110);
        advance(10, 1'b1);
        chk("R3 post catchup", fires[0], 64'd2110);

        // R6 truncation, R4 top bit cleared, 32-bit periodic wrap
        set_main(1'b0);
        wcfg(4'b0001);
        whi(32'h5);
        chk("R10 hi write", cmp, 64'h5_0000_0848);
        wcfg(4'b1111);
        chk("R6 truncate", cmp, 64'h848);
        wlo(32'hFFFF_FFF8);
        wlo(32'h8000_0010);
        chk("R4 period only", cmp, 64'hFFFF_FFF8);
        cnt = 64'h1_FFFF_FFF0;
        set_main(1'b1);
        advance(40, 1'b1);
        chk("R4 msb cleared count", 64'(nf), 64'd3);
        chk("R6 wrap reload", fires[1], 64'h2_0000_0008);
        chk("R6 cmp mod", cmp, 64'h28);
        set_main(1'b0);
        whi(32'h7);
        chk("R6 hi ignored", cmp, 64'h28);

        // R7 32-bit one-shot wrap event
        wcfg(4'b0101);
        wlo(32'h10);
        cnt = 64'h3_FFFF_FFF0;
        set_main(1'b1);
        advance(40, 1'b1);
        chk("R7 count", 64'(nf), 64'd2);
        chk("R7 wrap evt", fires[0], 64'h3_FFFF_FFFF);
        chk("R7 real match", fires[1], 64'h4_0000_0010);
        chk("R7 disarm", 64'(armed), 64'd0);

        // R9 comparator write rearms, no wrap when match comes first
        cnt = 64'h100;
        wlo(32'h120);
        advance(40, 1'b1);
        chk("R9 rearm count", 64'(nf), 64'd1);
        chk("R9 rearm value", fires[0], 64'h120);

        // R9 channel disable and re-enable
        cnt = 64'h200;
        wlo(32'h205);
        chk("R9 armed", 64'(armed), 64'd1);
        wcfg(4'b0100);
        chk("R9 disarmed", 64'(armed), 64'd0);
        advance(20, 1'b1);
        chk("R9 silent", 64'(nf), 64'd0);
        wcfg(4'b0101);
        advance(3, 1'b0);
        chk("R9 enable arms", 64'(nf), 64'd1);

        // R8 all-ones comparator is not armed by main enable
        set_main(1'b0);
        wcfg(4'b0001);
        whi(32'hFFFF_FFFF);
        wlo(32'hFFFF_FFFF);
        set_main(1'b1);
        chk("R8 all ones", 64'(armed), 64'd0);
        advance(5, 1'b1);
        chk("R8 all ones silent", 64'(nf), 64'd0);

        // R8 main enable low disarms
        cnt = 64'h1000;
        whi(32'h0);
        wlo(32'h1010);
        chk("R8 armed", 64'(armed), 64'd1);
        set_main(1'b0);
        chk("R8 main off", 64'(armed), 64'd0);
        advance(30, 1'b1);
        chk("R8 main off silent", 64'(nf), 64'd0);

        // R2 random one-shot trials
        for (int k = 0; k < 24; k++) begin
            base = {$urandom(), $urandom()};
            tgt  = base + 64'($urandom_range(20, 1));
            if (tgt == '1) tgt = tgt - 64'd2;
            set_main(1'b0);
            whi(tgt[63:32]);
            wlo(tgt[31:0]);
            cnt = base;
            set_main(1'b1);
            advance(24, 1'b1);
            chk("R2 random count", 64'(nf), 64'd1);
            chk("R2 random value", fires[0], tgt);
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule